// File: doc/BRIEF.md
# Dual-Channel Cosine Waveform Generator

This block drives two 8-bit DAC codes with cosine waveforms that come from one shared phase accumulator. A register-write port sets the accumulator step, which fixes the output frequency, and each channel's own shaping: a power-of-two attenuation, a choice between 0 and 180 degrees of phase, and a signed DC offset. Each channel is started and stopped on its own. While a channel runs, its code is refreshed every clock and its valid flag is high. A stopped channel sits at midscale.

The wave comes from a cosine lookup that stores a quarter wave and rebuilds the other three quarters by folding. Both channels read the same sample in the same cycle, so they stay phase-locked to each other. Once any channel is running, the shared step can only change to a different value if the write carries a force flag. This stops one user from quietly retuning another user's tone.

Top module: `cosgen_dual`

## Requirements
- R1: After reset, and whenever a channel is stopped, its code is 128 and its valid flag is low. Both error flags and the frequency-reject flag are low after reset.
- R2: A write to address 0 loads the 16-bit step. The accumulator advances by the step on every clock while any channel runs and is held at 0 while none runs. Its top 8 bits form the table index. With all channels idle for at least 3 cycles, starting a channel gives codes in clock n = 1, 2, ... after the start edge that use index 0 for n < 4 and index ((n-3)*step mod 65536) >> 8 from n = 3 on.
- R3: The wave sample for index i is W = round(127*cos(2*pi*i/256)), rounded half away from zero.
- R4: A write to address 1+2c loads channel c's settings. Bits [9:8] select an attenuation A, and the sample is arithmetically shifted right by A bits (full, 1/2, 1/4, 1/8).
- R5: Bits [11:10] of the settings pick the phase. The value 01 negates the attenuated sample (180 degrees). The values 00, 10 and 11 all leave it unchanged (0 degrees).
- R6: Bits [7:0] of the settings are a signed offset. The code is 128 plus the shaped sample plus the offset, saturated to 0..255.
- R7: A write to address 2+2c with bit 0 set starts channel c, and with bit 0 clear stops it. Channels start and stop independently. The valid flag rises one cycle after the start edge. The code returns to 128 with valid low one cycle after the stop edge.
- R8: Starting a running channel or stopping a stopped one raises that channel's error flag for one cycle and leaves its run state unchanged.
- R9: Both channels use the same accumulator sample in every cycle.
- R10: While any channel runs, a step write with a different value and the force input low is rejected. The step is kept and the reject flag pulses for one cycle. A write of the same value, a forced write, or any write while all channels are idle is accepted without a reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| wr_force | input | 1 | Allows a step change while a channel runs |
| dac_code | output | 16 | Channel codes, channel c in bits [8c+7:8c] |
| dac_valid | output | 2 | Per-channel output-valid flags |
| chan_err | output | 2 | Per-channel redundant start/stop pulse |
| freq_rej | output | 1 | Pulse for a rejected step write |

## Verification
A quarter-turn step makes the codes visit the peak, zero crossing and trough, which shows whether the index timing and the table folding are right. Odd steps such as 0x0500 and 0x0700 walk through every quadrant at uneven points, and there the shift-then-negate order and the rounding of each attenuation become visible. Large positive and negative offsets on the quarter-turn pattern drive the sum past both rails to test saturation. A second channel with inverted phase started mid-run, redundant start/stop commands, and step writes with and without force while running (each followed by a restart that shows which step was kept) separate the sharing, error and reject rules.

// File: rtl/cosgen_pkg.sv
package cosgen_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    PH_ZERO = 2'b00,
    PH_INV  = 2'b01,
    PH_RSV2 = 2'b10,
    PH_RSV3 = 2'b11
  } phase_sel_e;

  typedef struct packed {
    phase_sel_e        ph;
    logic [1:0]        atten;
    logic [CODE_W-1:0] offset;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/cosgen_phase_acc.sv
module cosgen_phase_acc #(
  parameter int ACC_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freq_we,
  input  logic             freq_force,
  input  logic [ACC_W-1:0] freq_data,
  input  logic             any_run,
  output logic [IDX_W-1:0] idx,
  output logic             freq_rej
);
  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] acc_q;
  logic             allow_w;

  assign allow_w = !any_run || freq_force || (freq_data == step_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= '0;
      freq_rej <= 1'b0;
    end else begin
      freq_rej <= freq_we && !allow_w;
      if (freq_we && allow_w) step_q <= freq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (any_run) acc_q <= acc_q + step_q;
    else              acc_q <= '0;
  end

  assign idx = acc_q[ACC_W-1 -: IDX_W];

  // R10
  freq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    freq_rej |-> $stable(step_q));

  // R10
  rej_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    freq_rej |-> $past(any_run));

  // R2
  acc_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !any_run |=> (acc_q == '0));
endmodule

// File: rtl/cosgen_wave_rom.sv
module cosgen_wave_rom #(
  parameter int IDX_W = 8,
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] wave
);
  localparam int QN     = 1 << (IDX_W - 2);
  localparam int QA_W   = IDX_W - 1;
  localparam int MAG_W  = AMP_W - 1;
  localparam int AMP    = (1 << MAG_W) - 1;
  localparam real TWO_PI = 6.283185307179586;

  logic [MAG_W-1:0] qrom [0:QN];

  initial begin
    for (int j = 0; j <= QN; j++) begin
      qrom[j] = MAG_W'($rtoi(real'(AMP) * $cos(TWO_PI * real'(j) / real'(4 * QN)) + 0.5));
    end
  end

  logic [1:0]        quad;
  logic [IDX_W-3:0]  kofs;
  logic [QA_W-1:0]   qaddr;
  logic [MAG_W-1:0]  rom_q;
  logic              neg_q;

  assign quad  = idx[IDX_W-1 -: 2];
  assign kofs  = idx[IDX_W-3:0];
  assign qaddr = quad[0] ? (QA_W'(QN) - QA_W'(kofs)) : QA_W'(kofs);

  always_ff @(posedge clk) begin
    rom_q <= qrom[qaddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
      wave  <= '0;
    end else begin
      neg_q <= quad[0] ^ quad[1];
      wave  <= neg_q ? -$signed({1'b0, rom_q}) : $signed({1'b0, rom_q});
    end
  end

  // R3
  wave_range_chk: assert property (@(posedge clk) disable iff (rst)
    wave >= -$signed(AMP_W'(AMP)));
endmodule

// File: rtl/cosgen_chan.sv
module cosgen_chan
  import cosgen_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 ctl_we,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 ctl_start,
  input  logic signed [CW-1:0] wave,
  output logic [CW-1:0]        code,
  output logic                 valid,
  output logic                 run,
  output logic                 err
);
  localparam int SUM_W = CW + 3;
  localparam int MID   = 1 << (CW - 1);
  localparam int MAXC  = (1 << CW) - 1;

  chan_cfg_t               cfg_q;
  logic signed [CW-1:0]    shifted;
  logic signed [CW-1:0]    shaped;
  logic signed [SUM_W-1:0] sum;
  logic [CW-1:0]           sat;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= chan_cfg_t'(cfg_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      err <= 1'b0;
    end else begin
      err <= ctl_we && (ctl_start == run);
      if (ctl_we) run <= ctl_start;
    end
  end

  always_comb begin
    shifted = wave >>> cfg_q.atten;
    shaped  = (cfg_q.ph == PH_INV) ? -shifted : shifted;
    sum     = SUM_W'(MID) + SUM_W'(shaped) + SUM_W'($signed(cfg_q.offset));
    if (sum[SUM_W-1])                 sat = '0;
    else if (sum > SUM_W'(MAXC))      sat = CW'(MAXC);
    else                              sat = sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= CW'(MID);
      valid <= 1'b0;
    end else begin
      code  <= run ? sat : CW'(MID);
      valid <= run;
    end
  end

  // R1
  idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (code == CW'(MID)));

  // R8
  err_run_stable_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(run));

  // R7
  start_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> valid);
endmodule

// File: rtl/cosgen_dual.sv
module cosgen_dual
  import cosgen_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ACC_W  = 16,
  parameter int IDX_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [$clog2(2*NUM_CH+1)-1:0]  wr_addr,
  input  logic [ACC_W-1:0]               wr_data,
  input  logic                           wr_force,
  output logic [NUM_CH*CODE_W-1:0]       dac_code,
  output logic [NUM_CH-1:0]              dac_valid,
  output logic [NUM_CH-1:0]              chan_err,
  output logic                           freq_rej
);
  localparam int ADDR_W = $clog2(2*NUM_CH+1);

  logic [NUM_CH-1:0]        run_vec;
  logic [IDX_W-1:0]         idx;
  logic signed [CODE_W-1:0] wave;
  logic                     freq_we;

  assign freq_we = wr_en && (wr_addr == ADDR_W'(0));

  cosgen_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .freq_we    (freq_we),
    .freq_force (wr_force),
    .freq_data  (wr_data),
    .any_run    (|run_vec),
    .idx        (idx),
    .freq_rej   (freq_rej)
  );

  cosgen_wave_rom #(.IDX_W(IDX_W), .AMP_W(CODE_W)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .idx  (idx),
    .wave (wave)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cfg_we_c;
    logic ctl_we_c;
    assign cfg_we_c = wr_en && (wr_addr == ADDR_W'(1 + 2*c));
    assign ctl_we_c = wr_en && (wr_addr == ADDR_W'(2 + 2*c));

    cosgen_chan #(.CW(CODE_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we_c),
      .ctl_we    (ctl_we_c),
      .cfg_data  (wr_data[CFG_W-1:0]),
      .ctl_start (wr_data[0]),
      .wave      (wave),
      .code      (dac_code[c*CODE_W +: CODE_W]),
      .valid     (dac_valid[c]),
      .run       (run_vec[c]),
      .err       (chan_err[c])
    );
  end
endmodule

// File: tb/cosgen_dual_tb.sv
module cosgen_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_force = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  dac_valid;
  logic [1:0]  chan_err;
  logic        freq_rej;

  int checks = 0;
  int fails  = 0;
  localparam real TWO_PI = 6.283185307179586;

  always #2 clk = ~clk;

  cosgen_dual dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_force(wr_force), .dac_code(dac_code), .dac_valid(dac_valid),
    .chan_err(chan_err), .freq_rej(freq_rej)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tval(input int i);
    real a = 127.0 * $cos(TWO_PI * real'(i) / 256.0);
    return (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
  endfunction

  function automatic int exp_code(input int i, input int at, input int ph, input int off);
    int v = tval(i) >>> at;
    int s;
    if (ph == 1) v = -v;
    s = 128 + v + off;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic int code_of(input int c);
    return int'(dac_code[c*8 +: 8]);
  endfunction

  task automatic wr(input int addr, input int data, input bit frc);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data); wr_force = frc;
    @(negedge clk);
    wr_en = 1'b0; wr_force = 1'b0;
  endtask

  task automatic set_cfg(input int c, input int at, input int ph, input int off);
    wr(1 + 2*c, ((ph & 3) << 10) | ((at & 3) << 8) | (off & 255), 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start channel c from all-idle and follow the R2 index timing
  task automatic start_and_follow(input string tag, input int c, input int step,
                                  input int at, input int ph, input int off, input int ncyc);
    wr(2 + 2*c, 1, 1'b0);
    check({tag, " R8 no err on start"}, int'(chan_err[c]), 0);
    for (int n = 1; n <= ncyc; n++) begin
      int i;
      @(negedge clk);
      i = (n < 3) ? 0 : ((((n - 3) * step) & 16'hffff) >> 8);
      check(tag, code_of(c), exp_code(i, at, ph, off));
    end
    check({tag, " R7 valid high"}, int'(dac_valid[c]), 1);
    wr(2 + 2*c, 0, 1'b0);
    @(negedge clk);
    check({tag, " R7 stop code"}, code_of(c), 128);
    check({tag, " R7 stop valid"}, int'(dac_valid[c]), 0);
    idle(4);
  endtask

  task automatic run_seq(input string tag, input int c, input int step,
                         input int at, input int ph, input int off, input int ncyc);
    set_cfg(c, at, ph, off);
    wr(0, step, 1'b0);
    idle(4);
    start_and_follow(tag, c, step, at, ph, off, ncyc);
  endtask

  task automatic t_reset;
    check("R1 reset code0", code_of(0), 128);
    check("R1 reset code1", code_of(1), 128);
    check("R1 reset valid", int'(dac_valid), 0);
    check("R1 reset err", int'(chan_err), 0);
    check("R1 reset rej", int'(freq_rej), 0);
  endtask

  task automatic t_basic;
    run_seq("R2 R3 quarter step ch0", 0, 16'h4000, 0, 0, 0, 10);
    run_seq("R2 R3 fine step ch1", 1, 16'h0300, 0, 0, 0, 24);
  endtask

  task automatic t_atten;
    run_seq("R4 atten1", 0, 16'h0700, 1, 0, 0, 16);
    run_seq("R4 atten2", 0, 16'h0700, 2, 0, 0, 16);
    run_seq("R4 atten3", 1, 16'h0700, 3, 0, 0, 16);
  endtask

  task automatic t_phase;
    run_seq("R5 inverted atten1", 0, 16'h0500, 1, 1, 0, 20);
    run_seq("R5 code10 falls back", 0, 16'h4000, 0, 2, 0, 8);
    run_seq("R5 code11 falls back", 1, 16'h0500, 0, 3, 0, 12);
  endtask

  task automatic t_offset;
    run_seq("R6 offset -20", 0, 16'h0500, 2, 1, -20, 20);
    run_seq("R6 saturate high", 0, 16'h4000, 0, 0, 100, 8);
    run_seq("R6 saturate low", 1, 16'h4000, 0, 0, -100, 8);
  endtask

  task automatic t_share;
    set_cfg(0, 0, 0, 0);
    set_cfg(1, 0, 1, 0);
    wr(0, 16'h0900, 1'b0);
    idle(4);
    wr(2, 1, 1'b0);
    idle(7);
    wr(4, 1, 1'b0);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      check("R9 shared sample ch1 vs ch0", code_of(1), 256 - code_of(0));
    end
    check("R9 both valid", int'(dac_valid), 3);
    // R7 stopping ch0 leaves ch1 running
    wr(2, 0, 1'b0);
    @(negedge clk);
    check("R7 indep ch0 stopped", int'(dac_valid[0]), 0);
    check("R7 indep ch1 runs", int'(dac_valid[1]), 1);
    wr(4, 0, 1'b0);
    idle(4);
  endtask

  task automatic t_err;
    set_cfg(0, 0, 0, 0);
    wr(2, 1, 1'b0);
    check("R8 first start", int'(chan_err[0]), 0);
    wr(2, 1, 1'b0);
    check("R8 redundant start", int'(chan_err[0]), 1);
    @(negedge clk);
    check("R8 err one cycle", int'(chan_err[0]), 0);
    check("R8 still running", int'(dac_valid[0]), 1);
    wr(4, 0, 1'b0);
    check("R8 redundant stop ch1", int'(chan_err[1]), 1);
    check("R8 ch0 unaffected", int'(chan_err[0]), 0);
    @(negedge clk);
    check("R8 ch1 stays stopped", int'(dac_valid[1]), 0);
    wr(2, 0, 1'b0);
    check("R8 normal stop", int'(chan_err[0]), 0);
    wr(2, 0, 1'b0);
    check("R8 redundant stop ch0", int'(chan_err[0]), 1);
    idle(4);
  endtask

  task automatic t_freq;
    set_cfg(0, 0, 0, 0);
    wr(0, 16'h1000, 1'b0);
    check("R10 idle write accepted", int'(freq_rej), 0);
    idle(4);
    wr(2, 1, 1'b0);
    idle(3);
    wr(0, 16'h2000, 1'b0);
    check("R10 change rejected", int'(freq_rej), 1);
    @(negedge clk);
    check("R10 reject one cycle", int'(freq_rej), 0);
    wr(0, 16'h1000, 1'b0);
    check("R10 same value no reject", int'(freq_rej), 0);
    wr(2, 0, 1'b0);
    idle(5);
    start_and_follow("R10 step kept after reject", 0, 16'h1000, 0, 0, 0, 12);
    wr(2, 1, 1'b0);
    idle(3);
    wr(0, 16'h3000, 1'b1);
    check("R10 forced write no reject", int'(freq_rej), 0);
    wr(2, 0, 1'b0);
    idle(5);
    start_and_follow("R10 forced step used", 0, 16'h3000, 0, 0, 0, 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_basic();
    t_atten();
    t_phase();
    t_offset();
    t_share();
    t_err();
    t_freq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule